// File: doc/BRIEF.md
# Memory Access Level Routing Stage

This block sits in the load/store path and decides, one request at a time, how each memory access is steered. Every request carries an address and two behaviour flags: a volatile-data flag (the access must see the values that other cores can see) and a no-cache flag (the access targets an active object such as a device register). Configuration inputs describe the coherence topology of the system and say whether the highest level shared by all cores is a shared cache or main memory. From these the stage works out three things: whether the address must pass through translation, which hierarchy level services the access, and whether the access may be cached.

A fixed window at the bottom of the virtual space, from address zero up to a parameterised limit, maps physical memory directly. Addresses in that window skip translation but are still cached unless no-cache is set. The decision is held in one output register with a valid/ready handshake, so every request takes exactly one cycle and stalls when the consumer stalls.

Top module: `mem_route_stage`

## Requirements
- R1: A request with neither flag set is routed to level code 0 (private first-level cache) with outCacheable = 1. Level codes are 0 = private cache, 1 = shared cache, 2 = memory, 3 = aperture.
- R2: When cfgTopology is 0 (single core) or 1 (coherent multicore), the volatile flag on its own changes nothing: the routing is the same as in R1.
- R3: When cfgTopology is 2 (incoherent multicore), a volatile request without no-cache is not cacheable. It goes to level 1 when cfgSharedIsMem = 0 and to level 2 when cfgSharedIsMem = 1. Topology code 3 is handled the same way as code 2.
- R4: A no-cache request goes to level 3 (aperture) with outCacheable = 0, whatever the topology.
- R5: When both flags are set, no-cache wins and R4 applies.
- R6: outTranslate is 0 when the 64-bit address is below WIN_LIMIT and 1 otherwise. This holds for every combination of flags and topology.
- R7: A request accepted on a rising edge (inValid and inReady both high) appears on the outputs after that edge, with outValid = 1 and its own address on outAddr.
- R8: While outValid = 1 and outReady = 0, the outputs stay unchanged and inReady is 0. inReady is 1 whenever the output register is empty or is being drained.
- R9: After reset, outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Stage can take a request |
| inAddr | input | ADDR_W | Virtual address of the request |
| inVolatile | input | 1 | Volatile-data behaviour flag |
| inNoCache | input | 1 | No-cache behaviour flag |
| cfgTopology | input | 2 | 0 single core, 1 coherent multicore, 2 or 3 incoherent multicore |
| cfgSharedIsMem | input | 1 | The highest level shared by all cores is memory (1) or a shared cache (0) |
| outValid | output | 1 | Routed request present |
| outReady | input | 1 | Consumer takes the routed request |
| outAddr | output | ADDR_W | Address passed through |
| outTranslate | output | 1 | Address must go through translation |
| outLevel | output | 2 | Target level code |
| outCacheable | output | 1 | Access may be cached |

## Verification
The two actions that can land on the same edge are handing the held result to the consumer and taking a new request into the register. The bench stalls the consumer with one request held and a second request waiting. It checks that the held fields do not change and that inReady stays low. It then releases outReady while the second request is still valid, so that one edge both drains the first result and loads the second. The outputs after that edge must be the second request's address and routing, with nothing lost and nothing duplicated.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

  typedef enum logic [1:0] {
    LVL_PRIV     = 2'd0,
    LVL_SHARED   = 2'd1,
    LVL_MEMORY   = 2'd2,
    LVL_APERTURE = 2'd3
  } level_e;

  // Topology codes; bit 1 set means the cores are not kept coherent.
  typedef enum logic [1:0] {
    TOPO_SINGLE     = 2'd0,
    TOPO_COHERENT   = 2'd1,
    TOPO_INCOHERENT = 2'd2,
    TOPO_INCOH_ALT  = 2'd3
  } topo_e;

  typedef struct packed {
    logic load;
  } strobe_t;

  typedef struct packed {
    logic   translate;
    level_e level;
    logic   cacheable;
  } route_t;

endpackage

// File: rtl/mrt_route_decode.sv
module mrt_route_decode
  import mrt_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] WIN_LIMIT = 64'h0000_0100_0000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              volatileFlag,
  input  logic              noCacheFlag,
  input  logic [1:0]        topology,
  input  logic              sharedIsMem,
  output route_t            route
);

  logic inWindow;
  logic incoherent;

  assign inWindow   = (addr < WIN_LIMIT);
  assign incoherent = topology[1];

  always_comb begin
    route.translate = ~inWindow;
    if (noCacheFlag) begin
      route.level     = LVL_APERTURE;
      route.cacheable = 1'b0;
    end else if (volatileFlag && incoherent) begin
      route.level     = sharedIsMem ? LVL_MEMORY : LVL_SHARED;
      route.cacheable = 1'b0;
    end else begin
      route.level     = LVL_PRIV;
      route.cacheable = 1'b1;
    end
  end

endmodule

// File: rtl/mrt_ctrl.sv
module mrt_ctrl
  import mrt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  input  logic    outReady,
  output logic    outValid,
  output strobe_t strobes
);

  logic validQ;

  assign inReady      = ~validQ | outReady;
  assign strobes.load = inValid & inReady;
  assign outValid     = validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobes.load) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

endmodule

// File: rtl/mrt_datapath.sv
module mrt_datapath
  import mrt_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] WIN_LIMIT = 64'h0000_0100_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inVolatile,
  input  logic              inNoCache,
  input  logic [1:0]        cfgTopology,
  input  logic              cfgSharedIsMem,
  output logic [ADDR_W-1:0] outAddr,
  output route_t            outRoute
);

  route_t nextRoute;

  mrt_route_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_LIMIT(WIN_LIMIT)
  ) u_decode (
    .addr        (inAddr),
    .volatileFlag(inVolatile),
    .noCacheFlag (inNoCache),
    .topology    (cfgTopology),
    .sharedIsMem (cfgSharedIsMem),
    .route       (nextRoute)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAddr  <= '0;
      outRoute <= '{translate: 1'b0, level: LVL_PRIV, cacheable: 1'b0};
    end else if (strobes.load) begin
      outAddr  <= inAddr;
      outRoute <= nextRoute;
    end
  end

endmodule

// File: rtl/mem_route_stage.sv
module mem_route_stage
  import mrt_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] WIN_LIMIT = 64'h0000_0100_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inVolatile,
  input  logic              inNoCache,
  input  logic [1:0]        cfgTopology,
  input  logic              cfgSharedIsMem,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outTranslate,
  output logic [1:0]        outLevel,
  output logic              outCacheable
);

  strobe_t strobes;
  route_t  routeQ;

  mrt_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .outReady(outReady),
    .outValid(outValid),
    .strobes (strobes)
  );

  mrt_datapath #(
    .ADDR_W   (ADDR_W),
    .WIN_LIMIT(WIN_LIMIT)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .inAddr        (inAddr),
    .inVolatile    (inVolatile),
    .inNoCache     (inNoCache),
    .cfgTopology   (cfgTopology),
    .cfgSharedIsMem(cfgSharedIsMem),
    .outAddr       (outAddr),
    .outRoute      (routeQ)
  );

  assign outTranslate = routeQ.translate;
  assign outLevel     = routeQ.level;
  assign outCacheable = routeQ.cacheable;

endmodule

// File: rtl/mrt_checker.sv
module mrt_checker #(
  parameter int unsigned       ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] WIN_LIMIT = 64'h0000_0100_0000_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [ADDR_W-1:0] inAddr,
  input logic              inVolatile,
  input logic              inNoCache,
  input logic [1:0]        cfgTopology,
  input logic              cfgSharedIsMem,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] outAddr,
  input logic              outTranslate,
  input logic [1:0]        outLevel,
  input logic              outCacheable
);

  logic accept;
  assign accept = inValid & inReady;

  AST_PLAIN_PRIVATE: assert property (@(posedge clk) disable iff (!rstN)
    accept && !inNoCache && !inVolatile |=> outLevel == 2'd0 && outCacheable); // R1

  AST_VOLATILE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    accept && !inNoCache && !cfgTopology[1] |=> outLevel == 2'd0 && outCacheable); // R2

  AST_INCOHERENT_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    accept && !inNoCache && inVolatile && cfgTopology[1]
    |=> !outCacheable && outLevel == ($past(cfgSharedIsMem) ? 2'd2 : 2'd1)); // R3

  AST_NOCACHE_APERTURE: assert property (@(posedge clk) disable iff (!rstN)
    accept && inNoCache |=> outLevel == 2'd3 && !outCacheable); // R4

  AST_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    accept && inNoCache && inVolatile |=> outLevel == 2'd3); // R5

  AST_WINDOW_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outTranslate == ($past(inAddr) >= WIN_LIMIT)); // R6

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outValid && outAddr == $past(inAddr)); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outLevel)
                              && $stable(outTranslate) && $stable(outCacheable)); // R8

  AST_NO_READY_STALL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady); // R8

endmodule

bind mem_route_stage mrt_checker #(
  .ADDR_W   (ADDR_W),
  .WIN_LIMIT(WIN_LIMIT)
) u_mrt_checker (
  .clk           (clk),
  .rstN          (rstN),
  .inValid       (inValid),
  .inReady       (inReady),
  .inAddr        (inAddr),
  .inVolatile    (inVolatile),
  .inNoCache     (inNoCache),
  .cfgTopology   (cfgTopology),
  .cfgSharedIsMem(cfgSharedIsMem),
  .outValid      (outValid),
  .outReady      (outReady),
  .outAddr       (outAddr),
  .outTranslate  (outTranslate),
  .outLevel      (outLevel),
  .outCacheable  (outCacheable)
);

// File: tb/test_mem_route_stage.sv
module test_mem_route_stage;

  localparam int unsigned ADDR_W = 64;
  localparam logic [63:0] LIMIT  = 64'h0000_0100_0000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inAddr = '0;
  logic        inVolatile = 1'b0;
  logic        inNoCache = 1'b0;
  logic [1:0]  cfgTopology = 2'd0;
  logic        cfgSharedIsMem = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] outAddr;
  logic        outTranslate;
  logic [1:0]  outLevel;
  logic        outCacheable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mem_route_stage #(.ADDR_W(ADDR_W), .WIN_LIMIT(LIMIT)) i_mem_route_stage (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inAddr(inAddr),
    .inVolatile(inVolatile), .inNoCache(inNoCache), .cfgTopology(cfgTopology),
    .cfgSharedIsMem(cfgSharedIsMem), .outValid(outValid), .outReady(outReady),
    .outAddr(outAddr), .outTranslate(outTranslate), .outLevel(outLevel),
    .outCacheable(outCacheable)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pickAddr(input int k);
    case (k)
      0: return 64'd0;
      1: return LIMIT - 64'd1;
      2: return LIMIT;
      3: return 64'h0000_0000_1234_5678;
      default: return 64'hFFFF_FFFF_FFFF_FFF0;
    endcase
  endfunction

  // Expected routing per the requirements: {level, cacheable}.
  function automatic logic [2:0] expRoute(input logic vol, input logic nc,
                                          input logic [1:0] topo, input logic shMem);
    if (nc) return {2'd3, 1'b0};                     // R4, R5
    if (vol && topo >= 2) return {(shMem ? 2'd2 : 2'd1), 1'b0}; // R3
    return {2'd0, 1'b1};                             // R1, R2
  endfunction

  task automatic sendOne(input logic [63:0] a, input logic vol, input logic nc,
                         input logic [1:0] topo, input logic shMem);
    logic [2:0] e;
    string req;
    e = expRoute(vol, nc, topo, shMem);
    if (nc) req = vol ? "R5" : "R4";
    else if (vol && topo >= 2) req = "R3";
    else if (vol) req = "R2";
    else req = "R1";
    @(negedge clk);
    inAddr = a; inVolatile = vol; inNoCache = nc; cfgTopology = topo;
    cfgSharedIsMem = shMem; inValid = 1'b1;
    check(inReady == 1'b1, "R8 ready when empty", {63'd0, inReady}, 64'd1);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1 && outAddr == a, "R7", outAddr, a);
    check({outLevel, outCacheable} == e, req, {61'd0, outLevel, outCacheable}, {61'd0, e});
    check(outTranslate == (a >= LIMIT), "R6", {63'd0, outTranslate},
          {63'd0, (a >= LIMIT)});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R9", {63'd0, outValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && inReady == 1'b1, "R9", {62'd0, outValid, inReady}, 64'd1);

    // Sweep over topology, shared-level choice, flags and addresses.
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < 2; s++)
        for (int f = 0; f < 4; f++)
          for (int k = 0; k < 5; k++)
            sendOne(pickAddr(k), f[0], f[1], t[1:0], s[0]);

    // R8: stall with one held, one waiting; then drain and load on the same edge.
    @(negedge clk);
    outReady = 1'b0;
    inAddr = 64'h10; inVolatile = 1'b0; inNoCache = 1'b1; cfgTopology = 2'd0;
    cfgSharedIsMem = 1'b0; inValid = 1'b1;
    @(negedge clk);
    inAddr = LIMIT + 64'h40; inVolatile = 1'b1; inNoCache = 1'b0; cfgTopology = 2'd2;
    cfgSharedIsMem = 1'b1;
    check(inReady == 1'b0, "R8 not ready when stalled", {63'd0, inReady}, 64'd0);
    repeat (3) @(negedge clk);
    check(outValid && outAddr == 64'h10, "R8 held address", outAddr, 64'h10);
    check(outLevel == 2'd3 && !outCacheable && !outTranslate, "R8 held route",
          {61'd0, outLevel, outCacheable}, {61'd0, 2'd3, 1'b0});
    check(inReady == 1'b0, "R8 ready stays low", {63'd0, inReady}, 64'd0);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid && outAddr == LIMIT + 64'h40, "R8 drain and load", outAddr,
          LIMIT + 64'h40);
    check(outLevel == 2'd2 && !outCacheable && outTranslate, "R3 after stall",
          {61'd0, outLevel, outCacheable}, {61'd0, 2'd2, 1'b0});
    @(negedge clk);
    check(outValid == 1'b0, "R8 drained", {63'd0, outValid}, 64'd0);

    // R9: reset in the middle of traffic clears the output.
    inValid = 1'b1; inAddr = 64'h20;
    @(negedge clk);
    inValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R9 mid-run reset", {63'd0, outValid}, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule